// File: doc/BRIEF.md
# Buffered Time-over-Threshold Meter

This block measures how long a layer's combined hit signal (the OR of every discriminator output in one detector layer) stays high after a trigger acknowledge. The duration is counted in prescaled ticks of one tick per `PRESC` clocks and clipped at a fixed ceiling. Each trigger acknowledge opens one slot in a small in-order result queue. When the measurement for that trigger finishes, its value is written into the slot. Readout logic takes the results in trigger order, so every duration stays attached to its own event.

A new trigger acknowledge closes any measurement still running for the previous event, so a trigger that lands on the falling edge of the OR signal produces a clean, defined result. When no OR activity follows a trigger within a fixed window, the event's value is 0. While measurement is disabled, each trigger gets a fixed marker value at once. A trigger that finds the queue full is dropped, and the block flags an overflow.

Top module: `thr_dur_meter`

## Requirements
- R1: After reset the queue is empty: `head_valid` and `overflow` are 0.
- R2: With `meas_en`=1, if `layer_or` rises after an accepted trigger acknowledge and stays high for H clock cycles (H edges sampled high), the event's result is floor(H/`PRESC`). With the defaults this is floor(H/4), an unsigned 8-bit value on `head_value`. The result is written on the edge that first samples `layer_or` low.
- R3: The count saturates at `MAX_CNT` (default 250). The measurement closes with that value on the edge where the count would reach it, which is the 1000th high cycle with the defaults, even if `layer_or` stays high.
- R4: A measurement starts only on a rising edge of `layer_or` sampled strictly after the acknowledge edge. A level that is already high at acknowledge does not count until it falls and rises again.
- R5: If no rising edge follows within `WIN` (default 64) clock edges of the acknowledge, the event's result is 0. The result does not become readable before that point.
- R6: A trigger acknowledge accepted with `meas_en`=0 stores `DIS_VAL` (default 255). The result is ready on the following cycle.
- R7: Results leave in trigger order through a queue of `DEPTH` (default 4) entries. `head_valid` is 1 only when the oldest entry's result is final. A pulse on `rd_done` while `head_valid`=1 removes that entry.
- R8: A trigger acknowledge that finds the queue full, with no removal in the same cycle, is dropped. `overflow` is then high for exactly the next cycle, and the queue contents are unchanged.
- R9: A trigger acknowledge in the same cycle as the falling edge of `layer_or` closes the running measurement with its current count and opens a new armed measurement for the new event. Both entries remain in the queue.
- R10: `rd_done` while `head_valid`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_en | input | 1 | 1 = measure, 0 = store the fixed marker; sampled with each trigger acknowledge |
| layer_or | input | 1 | OR of the layer's discriminator outputs |
| trig_ack | input | 1 | One-cycle trigger acknowledge; opens one queue entry |
| rd_done | input | 1 | Readout consumed the head entry |
| head_valid | output | 1 | Oldest entry holds a final result |
| head_value | output | VW | Result of the oldest entry |
| overflow | output | 1 | One-cycle pulse after a dropped trigger acknowledge |

## Verification
The bench targets the edge collisions. A falling OR edge that coincides with a new acknowledge must leave two entries. A design that let the new trigger override the close would lose the old count or shift every later value by one event. Saturation is checked across a pulse longer than the ceiling, which would expose a counter that wraps to a small number or never closes. An OR level that is already high at acknowledge is checked to confirm that a level-sensitive start is not used. The bench also checks that an empty window gives 0 only after the timeout, and that a full queue drops exactly one trigger without corrupting entries or letting a stray `rd_done` remove an unfinished result.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_COUNT = 2'd2
   } meas_state_t;

endpackage

// File: rtl/tdm_edge.sv
module tdm_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic lvl_o,
   output logic rise_o
);

   logic lvl_prev;

   if (SYNC_STAGES == 0) begin : g_direct
      assign lvl_o = lvl_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] shreg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) shreg <= '0;
         else        shreg <= {shreg[SYNC_STAGES-2:0], lvl_i};
      end
      assign lvl_o = shreg[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= 1'b0;
      else        lvl_prev <= lvl_o;
   end

   assign rise_o = lvl_o & ~lvl_prev;

endmodule

// File: rtl/tdm_meter.sv
module tdm_meter
   import tdm_pkg::*;
#(
   parameter int VW      = 8,
   parameter int MAX_CNT = 250,
   parameter int PRESC   = 4,
   parameter int WIN     = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lvl_i,
   input  logic          rise_i,
   input  logic          start_i,
   input  logic          arm_i,
   output logic          close_o,
   output logic [VW-1:0] close_val_o
);

   localparam int TW = $clog2(WIN + 1);
   localparam logic [VW-1:0] CNT_LAST = VW'(MAX_CNT - 1);
   localparam logic [VW-1:0] CNT_SAT  = VW'(MAX_CNT);
   localparam logic [TW-1:0] WIN_LAST = TW'(WIN - 1);

   meas_state_t   st;
   logic [VW-1:0] cnt;
   logic [TW-1:0] tmr;
   logic          wrap_now;
   logic          rise_wrap;

   if (PRESC == 1) begin : g_no_presc
      assign wrap_now  = 1'b1;
      assign rise_wrap = 1'b1;
   end else begin : g_presc
      localparam int PW = $clog2(PRESC);
      localparam logic [PW-1:0] PH_LAST = PW'(PRESC - 1);
      logic [PW-1:0] ph;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          ph <= '0;
         else if (start_i)                    ph <= '0;
         else if (st == ST_ARMED && rise_i)   ph <= PW'(1);
         else if (st == ST_COUNT)             ph <= (ph == PH_LAST) ? '0 : ph + PW'(1);
      end
      assign wrap_now  = (ph == PH_LAST);
      assign rise_wrap = 1'b0;
   end

   always_comb begin
      close_o     = 1'b0;
      close_val_o = cnt;
      if (start_i) begin
         close_o     = (st != ST_IDLE);
         close_val_o = (st == ST_ARMED) ? '0 : cnt;
      end else begin
         case (st)
            ST_ARMED: if (!rise_i && tmr == WIN_LAST) begin
               close_o     = 1'b1;
               close_val_o = '0;
            end
            ST_COUNT: if (!lvl_i) begin
               close_o     = 1'b1;
               close_val_o = cnt;
            end else if (wrap_now && cnt == CNT_LAST) begin
               close_o     = 1'b1;
               close_val_o = CNT_SAT;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
         tmr <= '0;
      end else if (start_i) begin
         st  <= arm_i ? ST_ARMED : ST_IDLE;
         cnt <= '0;
         tmr <= '0;
      end else begin
         case (st)
            ST_ARMED: begin
               if (rise_i) begin
                  st  <= ST_COUNT;
                  cnt <= rise_wrap ? VW'(1) : '0;
               end else if (tmr == WIN_LAST) begin
                  st <= ST_IDLE;
               end else begin
                  tmr <= tmr + TW'(1);
               end
            end
            ST_COUNT: begin
               if (!lvl_i)                   st  <= ST_IDLE;
               else if (wrap_now) begin
                  if (cnt == CNT_LAST)       st  <= ST_IDLE;
                  else                       cnt <= cnt + VW'(1);
               end
            end
            default: ;
         endcase
      end
   end

   // R3: no result ever exceeds the ceiling
   p_sat_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      close_o |-> close_val_o <= CNT_SAT);

   // R2: between prescaler wraps the count holds
   p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_COUNT && lvl_i && !start_i && !wrap_now) |=> $stable(cnt));

endmodule

// File: rtl/tdm_queue.sv
module tdm_queue #(
   parameter int DEPTH = 4,
   parameter int VW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          push_ready_i,
   input  logic [VW-1:0] push_val_i,
   input  logic          close_i,
   input  logic [VW-1:0] close_val_i,
   input  logic          pop_req_i,
   output logic          full_o,
   output logic          pop_o,
   output logic          head_valid_o,
   output logic [VW-1:0] head_val_o
);

   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL_OCC = (AW+1)'(DEPTH);

   logic [VW-1:0]    val_q [DEPTH];
   logic [DEPTH-1:0] done_q;
   logic [AW-1:0]    wr_ptr, rd_ptr, open_idx;
   logic [AW:0]      occ;

   assign full_o       = (occ == FULL_OCC);
   assign head_valid_o = (occ != '0) && done_q[rd_ptr];
   assign head_val_o   = val_q[rd_ptr];
   assign pop_o        = pop_req_i && head_valid_o;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q[i]  <= '0;
            done_q[i] <= 1'b0;
         end else if (push_i && wr_ptr == AW'(i)) begin
            val_q[i]  <= push_val_i;
            done_q[i] <= push_ready_i;
         end else if (close_i && open_idx == AW'(i)) begin
            val_q[i]  <= close_val_i;
            done_q[i] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         open_idx <= '0;
         occ      <= '0;
      end else begin
         if (push_i) wr_ptr <= wr_ptr + AW'(1);
         if (pop_o)  rd_ptr <= rd_ptr + AW'(1);
         if (push_i && !push_ready_i) open_idx <= wr_ptr;
         case ({push_i, pop_o})
            2'b10:   occ <= occ + (AW+1)'(1);
            2'b01:   occ <= occ - (AW+1)'(1);
            default: ;
         endcase
      end
   end

   // R7: occupancy never exceeds the queue depth
   p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= FULL_OCC);

   // R9: a closing result always lands on a live, unfinished entry
   p_close_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
      close_i |-> (occ != '0) && !done_q[open_idx]);

   // R10: a removal request without a ready head leaves occupancy alone
   p_ignored_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req_i && !head_valid_o && !push_i) |=> occ == $past(occ));

endmodule

// File: rtl/thr_dur_meter.sv
module thr_dur_meter #(
   parameter int VW          = 8,
   parameter int MAX_CNT     = 250,
   parameter int PRESC       = 4,
   parameter int WIN         = 64,
   parameter int DEPTH       = 4,
   parameter int DIS_VAL     = 255,
   parameter int SYNC_STAGES = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          meas_en,
   input  logic          layer_or,
   input  logic          trig_ack,
   input  logic          rd_done,
   output logic          head_valid,
   output logic [VW-1:0] head_value,
   output logic          overflow
);

   localparam logic [VW-1:0] DIS_W = VW'(DIS_VAL);

   initial begin : p_param_chk
      assert (MAX_CNT >= 2 && MAX_CNT < (1 << VW)) else $error("MAX_CNT out of range");
      assert (DIS_VAL >= 0 && DIS_VAL < (1 << VW)) else $error("DIS_VAL out of range");
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0) else $error("DEPTH must be a power of two");
      assert (PRESC >= 1 && WIN >= 1 && SYNC_STAGES >= 0) else $error("bad timing parameters");
   end

   logic          or_s, or_rise;
   logic          q_full, q_pop, accept;
   logic          m_close;
   logic [VW-1:0] m_close_val;

   assign accept = trig_ack && (!q_full || q_pop);

   tdm_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (layer_or),
      .lvl_o  (or_s),
      .rise_o (or_rise)
   );

   tdm_meter #(.VW(VW), .MAX_CNT(MAX_CNT), .PRESC(PRESC), .WIN(WIN)) meter_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .lvl_i       (or_s),
      .rise_i      (or_rise),
      .start_i     (accept),
      .arm_i       (accept && meas_en),
      .close_o     (m_close),
      .close_val_o (m_close_val)
   );

   tdm_queue #(.DEPTH(DEPTH), .VW(VW)) queue_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .push_i       (accept),
      .push_ready_i (!meas_en),
      .push_val_i   (meas_en ? '0 : DIS_W),
      .close_i      (m_close),
      .close_val_i  (m_close_val),
      .pop_req_i    (rd_done),
      .full_o       (q_full),
      .pop_o        (q_pop),
      .head_valid_o (head_valid),
      .head_val_o   (head_value)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) overflow <= 1'b0;
      else        overflow <= trig_ack && q_full && !q_pop;
   end

   // R8: an overflow pulse is always caused by an acknowledge one cycle earlier
   p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> $past(trig_ack));

   // R8: overflow lasts a single cycle unless acknowledges keep arriving
   p_ovf_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !trig_ack) |=> !overflow);

endmodule

// File: tb/thr_dur_meter_tb_top.sv
module thr_dur_meter_tb_top;

   localparam int VW = 8, MAXC = 250, PRESC = 4, WIN = 64, DEPTH = 4, DIS = 255;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic meas_en = 1'b1, layer_or = 1'b0, trig_ack = 1'b0, rd_done = 1'b0;
   logic head_valid, overflow;
   logic [VW-1:0] head_value;

   always #5 clk = ~clk;

   thr_dur_meter #(.VW(VW), .MAX_CNT(MAXC), .PRESC(PRESC), .WIN(WIN),
                   .DEPTH(DEPTH), .DIS_VAL(DIS), .SYNC_STAGES(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .layer_or(layer_or),
      .trig_ack(trig_ack), .rd_done(rd_done), .head_valid(head_valid),
      .head_value(head_value), .overflow(overflow));

   int    n_run = 0, n_fail = 0, n_cyc = 0;
   string cur_req = "R1";
   bit    finished = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: per-sequence result store and a measurement state
   int mval[int];
   bit mdone[int];
   int hs = 0, ts = 0, os = 0;
   int mst = 0, mcnt = 0, mph = 0, mtmr = 0;
   bit mprev = 0, movf = 0;

   always @(posedge clk) begin
      bit rise, hv, pop, full, acc, closing;
      int cv, occ;
      if (!rst_n) begin
         hs = 0; ts = 0; os = 0; mst = 0; mcnt = 0; mph = 0; mtmr = 0;
         mprev = 0; movf = 0;
      end else begin
         rise = layer_or && !mprev;
         occ  = ts - hs;
         hv   = (occ > 0) && mdone[hs];
         pop  = rd_done && hv;
         full = (occ == DEPTH);
         acc  = trig_ack && (!full || pop);
         closing = 0; cv = 0;
         if (acc) begin
            if (mst != 0) begin closing = 1; cv = (mst == 1) ? 0 : mcnt; end
            mst = meas_en ? 1 : 0; mcnt = 0; mph = 0; mtmr = 0;
         end else if (mst == 1) begin
            if (rise) begin mst = 2; mcnt = 0; mph = 1; end
            else if (mtmr == WIN - 1) begin closing = 1; cv = 0; mst = 0; end
            else mtmr++;
         end else if (mst == 2) begin
            if (!layer_or) begin closing = 1; cv = mcnt; mst = 0; end
            else if (mph == PRESC - 1) begin
               mph = 0;
               if (mcnt + 1 == MAXC) begin closing = 1; cv = MAXC; mst = 0; end
               else mcnt++;
            end else mph++;
         end
         if (closing) begin mval[os] = cv; mdone[os] = 1; end
         if (pop) hs++;
         if (acc) begin
            mval[ts] = meas_en ? 0 : DIS;
            mdone[ts] = !meas_en;
            if (meas_en) os = ts;
            ts++;
         end
         movf = trig_ack && full && !pop;
         mprev = layer_or;
      end
      #2;
      begin
         bit exp_hv;
         exp_hv = (ts - hs > 0) && mdone[hs];
         check(head_valid == exp_hv, cur_req, int'(head_valid), int'(exp_hv));
         check(overflow == movf, cur_req, int'(overflow), int'(movf));
         if (exp_hv) check(head_value == mval[hs], cur_req, int'(head_value), mval[hs]);
      end
   end

   always @(posedge clk) begin
      n_cyc++;
      if (n_cyc > 150000 && !finished) begin
         finished = 1;
         n_fail++; n_run++;
         $display("FAIL watchdog: actual %0d expected %0d", n_cyc, 150000);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ack(input bit en);
      @(negedge clk); trig_ack = 1'b1; meas_en = en;
      @(negedge clk); trig_ack = 1'b0;
   endtask

   task automatic pulse(input int h);
      @(negedge clk); layer_or = 1'b1;
      repeat (h) @(negedge clk);
      layer_or = 1'b0;
   endtask

   task automatic pop_expect(input int exp, input string req);
      int n = 0;
      while (!head_valid && n < 3000) begin @(negedge clk); n++; end
      check(head_valid && head_value == exp, req, int'(head_value), exp);
      rd_done = 1'b1;
      @(negedge clk); rd_done = 1'b0;
   endtask

   initial begin
      idle(3);
      check(head_valid == 1'b0 && overflow == 1'b0, "R1", int'(head_valid), 0);
      rst_n = 1'b1;
      idle(2);
      check(head_valid == 1'b0, "R1", int'(head_valid), 0);

      cur_req = "R2";
      ack(1); idle(3); pulse(40); pop_expect(10, "R2");
      ack(1); idle(1); pulse(7);  pop_expect(1, "R2");

      cur_req = "R3";
      ack(1); idle(2); pulse(1200); pop_expect(250, "R3");
      idle(2);

      cur_req = "R4";
      @(negedge clk); layer_or = 1'b1;
      idle(2); ack(1); idle(20); layer_or = 1'b0;
      pop_expect(0, "R4");

      cur_req = "R5";
      ack(1); idle(30);
      check(head_valid == 1'b0, "R5", int'(head_valid), 0);
      pop_expect(0, "R5");

      cur_req = "R6";
      ack(0);
      check(head_valid == 1'b1 && head_value == DIS, "R6", int'(head_value), DIS);
      rd_done = 1'b1; @(negedge clk); rd_done = 1'b0;

      cur_req = "R7";
      ack(1); idle(2);
      @(negedge clk); layer_or = 1'b1;
      idle(8);
      check(head_valid == 1'b0, "R7", int'(head_valid), 0);
      layer_or = 1'b0;
      ack(0);
      pop_expect(2, "R7");
      pop_expect(DIS, "R7");

      cur_req = "R8";
      ack(0); ack(0); ack(0); ack(0);
      @(negedge clk); trig_ack = 1'b1;
      @(negedge clk); trig_ack = 1'b0;
      check(overflow == 1'b1, "R8", int'(overflow), 1);
      @(negedge clk);
      check(overflow == 1'b0, "R8", int'(overflow), 0);
      for (int k = 0; k < 4; k++) pop_expect(DIS, "R8");
      check(head_valid == 1'b0, "R8", int'(head_valid), 0);

      cur_req = "R9";
      ack(1); idle(2);
      @(negedge clk); layer_or = 1'b1;
      idle(12);
      layer_or = 1'b0; trig_ack = 1'b1; meas_en = 1'b1;
      @(negedge clk); trig_ack = 1'b0;
      pop_expect(3, "R9");
      pop_expect(0, "R9");

      cur_req = "R10";
      rd_done = 1'b1; idle(3); rd_done = 1'b0;
      check(head_valid == 1'b0, "R10", int'(head_valid), 0);
      ack(1);
      rd_done = 1'b1; @(negedge clk); rd_done = 1'b0;
      check(head_valid == 1'b0, "R10", int'(head_valid), 0);
      pulse(4);
      pop_expect(1, "R10");
      idle(4);

      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule